// File: doc/BRIEF.md
# Crypto Command Queue Sequencer

This block sits between a host register port and a cipher engine. The host writes 32-bit command words one at a time into a queue port. The sequencer buffers them in a short queue and reads the opcode from the top nibble of the first word. It works out how many payload words that command needs. Once those words are present, it either handles the command itself (flag commands) or hands it to the downstream engine with a one-cycle strobe. Each dispatch carries the header, every payload word and the address and length fields already extracted.

A dispatched command stays in the queue until the engine answers. A done response empties the queue. An error response keeps every word, and decode runs again on the next queue write. A small register window exposes status, interrupt status (write-one-to-clear), interrupt enable, watermark, queue status and the last flag information byte. One interrupt line is driven from interrupt status and interrupt enable.

Top module: `cmdq_seq`

## Requirements
- R1: The queue holds at most DEPTH words (9 by default). A queue write that arrives while the queue is full is dropped, and the words already queued are unchanged.
- R2: The opcode is bits [31:28] of the first queued word. The values 1 (key), 2 (IV load), 5 (data), 6 (IV store) and 8 (flag) are recognised. Decoding any other value sets interrupt status bit 2.
- R3: A command is complete when the queue holds its header plus its payload. An IV load needs 4 payload words, a data command 3 and an IV store 1. A key command with a non-zero selector in bits [26:24] needs none. A key command with a zero selector needs 4, 6 or 8 words for length code 0, 1 or 2 in bits [23:22]. A key command with length code 3, or with bits [17:16] above 1, is rejected without dispatch and without setting any interrupt bit.
- R4: Decode is tried after every queue write. An incomplete or rejected command leaves the queued words in place. A completed flag command empties the queue.
- R5: A flag command copies its bits [7:0] into the flag info register. If its bit 27 is set, it also sets interrupt status bit 5 in the same cycle.
- R6: A write to interrupt status clears each bit that is 1 in the written value. A write to interrupt enable replaces it. The interrupt output is high when any bit is set in both registers.
- R7: The registers sit at these offsets: status 0x0C, interrupt status 0x18, interrupt enable 0x1C, watermark 0x20, queue status 0x24, flag info 0x30, queue port 0x200. After reset, status reads 0x3F80 and queue status reads 2. Interrupt status, interrupt enable, watermark and flag info read 0. The queue port reads 0.
- R8: For a data command the length output is header bits [23:0]. The 48-bit source address is {payload1[31:16], payload2}. The 48-bit destination address is {payload1[15:0], payload3}.
- R9: For an IV store, the 40-bit address output is {header[7:0], payload1}.
- R10: Reads of unmapped offsets return 0. Writes to unmapped or read-only offsets change no register and leave the interrupt line as it was.
- R11: The dispatch strobe is high for exactly one cycle, in the cycle after the completing write. A done response empties the queue. An error response keeps the queue, and the next queue write dispatches the command again.
- R12: While a dispatched command awaits its response, queue writes are stored but not decoded. A flag word written then has no effect on flag info or interrupt status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt line |
| cmd_valid | output | 1 | One-cycle dispatch strobe |
| cmd_op | output | 4 | Opcode of the queued command |
| cmd_hdr | output | 32 | Header word of the queued command |
| cmd_payload | output | (DEPTH-1)*32 | Payload words 1..DEPTH-1, word 1 in the low bits |
| cmd_len | output | 24 | Data command length |
| cmd_src | output | 48 | Data command source address |
| cmd_dst | output | 48 | Data command destination address |
| cmd_ivaddr | output | 40 | IV store address |
| cmd_done | input | 1 | Downstream success response |
| cmd_err | input | 1 | Downstream error response |

## Verification
The bench builds the block with DEPTH = 9 and AW = 12, the defaults. A queue of nine words is exactly the size of the longest accepted key command, so the bench can fill it. That makes two cases reachable: a write dropped against a full queue, and a re-dispatch of that full queue after an error response. The bench checks that the last payload word survives the dropped write. The 12-bit offset covers the queue port at 0x200 and leaves room for unmapped offsets on either side of the register block.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;
    localparam int WORD_W = 32;

    localparam int OFS_STATUS = 'h00C;
    localparam int OFS_IST    = 'h018;
    localparam int OFS_IEN    = 'h01C;
    localparam int OFS_WMARK  = 'h020;
    localparam int OFS_QSTAT  = 'h024;
    localparam int OFS_FINFO  = 'h030;
    localparam int OFS_QPORT  = 'h200;

    localparam logic [31:0] STATUS_INIT = 32'h0000_3F80;
    localparam logic [31:0] QSTAT_INIT  = 32'h0000_0002;

    localparam logic [3:0] OP_KEY  = 4'h1;
    localparam logic [3:0] OP_IVLD = 4'h2;
    localparam logic [3:0] OP_DATA = 4'h5;
    localparam logic [3:0] OP_IVST = 4'h6;
    localparam logic [3:0] OP_FLAG = 4'h8;

    localparam int IST_BADCMD = 2;
    localparam int IST_FLAG   = 5;

    typedef enum logic [2:0] {
        DK_PEND,
        DK_REJECT,
        DK_FLAG,
        DK_SEND,
        DK_UNKNOWN
    } dkind_e;
endpackage

// File: rtl/cmdq_store.sv
`timescale 1ns/1ps
module cmdq_store #(
    parameter int DEPTH = 9,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic                        flush,
    input  logic [31:0]                 wdata,
    output logic [DEPTH-1:0][31:0]      words,
    output logic [CNT_W-1:0]            cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][31:0] words;
        logic [CNT_W-1:0]       cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // append first, then an empty request wipes everything
        if (push && (st_q.cnt < FULL)) begin
            st_d.words[st_q.cnt] = wdata;
            st_d.cnt             = st_q.cnt + 1'b1;
        end
        if (flush) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words = st_q.words;
    assign cnt   = st_q.cnt;

    // R1: occupancy never passes the queue size
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);

    // R1: a write against a full queue leaves it untouched
    a_r1_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && st_q.cnt == FULL) |=> (st_q.cnt == FULL) && $stable(st_q.words));
endmodule

// File: rtl/cmdq_decode.sv
`timescale 1ns/1ps
module cmdq_decode
    import cmdq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [3:0]       op,
    input  logic [2:0]       key_sel,
    input  logic [1:0]       key_len,
    input  logic [1:0]       blk_mode,
    input  logic [CNT_W-1:0] avail,
    output dkind_e           kind
);
    int     need;
    dkind_e base;

    always_comb begin
        need = 1;
        base = DK_SEND;
        case (op)
            OP_KEY: begin
                if (blk_mode > 2'd1) begin
                    base = DK_REJECT;
                end else if (key_sel != 3'd0) begin
                    need = 1;
                end else begin
                    case (key_len)
                        2'd0:    need = 5;
                        2'd1:    need = 7;
                        2'd2:    need = 9;
                        default: base = DK_REJECT;
                    endcase
                end
            end
            OP_IVLD: need = 5;
            OP_DATA: need = 4;
            OP_IVST: need = 2;
            OP_FLAG: base = DK_FLAG;
            default: base = DK_UNKNOWN;
        endcase
        kind = base;
        if (base == DK_SEND && int'(avail) < need) begin
            kind = DK_PEND;
        end
    end
endmodule

// File: rtl/cmdq_fields.sv
`timescale 1ns/1ps
module cmdq_fields (
    input  logic [23:0] hdr_lo,
    input  logic [31:0] pw1,
    input  logic [31:0] pw2,
    input  logic [31:0] pw3,
    output logic [23:0] len,
    output logic [47:0] src,
    output logic [47:0] dst,
    output logic [39:0] ivaddr
);
    always_comb begin
        len    = hdr_lo;
        src    = {pw1[31:16], pw2};
        dst    = {pw1[15:0],  pw3};
        ivaddr = {hdr_lo[7:0], pw1};
    end
endmodule

// File: rtl/cmdq_seq.sv
`timescale 1ns/1ps
module cmdq_seq
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 9,
    parameter int AW    = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [AW-1:0]             reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic                      irq,
    output logic                      cmd_valid,
    output logic [3:0]                cmd_op,
    output logic [31:0]               cmd_hdr,
    output logic [(DEPTH-1)*32-1:0]   cmd_payload,
    output logic [23:0]               cmd_len,
    output logic [47:0]               cmd_src,
    output logic [47:0]               cmd_dst,
    output logic [39:0]               cmd_ivaddr,
    input  logic                      cmd_done,
    input  logic                      cmd_err
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    localparam logic [AW-1:0] A_STATUS = AW'(OFS_STATUS);
    localparam logic [AW-1:0] A_IST    = AW'(OFS_IST);
    localparam logic [AW-1:0] A_IEN    = AW'(OFS_IEN);
    localparam logic [AW-1:0] A_WMARK  = AW'(OFS_WMARK);
    localparam logic [AW-1:0] A_QSTAT  = AW'(OFS_QSTAT);
    localparam logic [AW-1:0] A_FINFO  = AW'(OFS_FINFO);
    localparam logic [AW-1:0] A_QPORT  = AW'(OFS_QPORT);

    typedef struct packed {
        logic        busy;
        logic        valid;
        logic [31:0] ist;
        logic [31:0] ien;
        logic [7:0]  finfo;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [DEPTH-1:0][31:0] words;
    logic [CNT_W-1:0]       q_cnt;
    logic                   fifo_wr;
    logic                   first_new;
    logic [CNT_W-1:0]       avail_now;
    logic [3:0]             now_op;
    logic [2:0]             now_sel;
    logic [1:0]             now_klen;
    logic [1:0]             now_mode;
    logic                   now_raise;
    logic [7:0]             now_info;
    logic                   q_flush;
    dkind_e                 kind;

    // view of the queue as it stands after this cycle's write
    assign fifo_wr   = reg_wr && (reg_addr == A_QPORT);
    assign first_new = (q_cnt == '0);
    assign avail_now = (q_cnt == FULL) ? q_cnt : q_cnt + 1'b1;
    assign now_op    = first_new ? reg_wdata[31:28] : words[0][31:28];
    assign now_sel   = first_new ? reg_wdata[26:24] : words[0][26:24];
    assign now_klen  = first_new ? reg_wdata[23:22] : words[0][23:22];
    assign now_mode  = first_new ? reg_wdata[17:16] : words[0][17:16];
    assign now_raise = first_new ? reg_wdata[27]    : words[0][27];
    assign now_info  = first_new ? reg_wdata[7:0]   : words[0][7:0];

    cmdq_decode #(.CNT_W(CNT_W)) u_dec (
        .op       (now_op),
        .key_sel  (now_sel),
        .key_len  (now_klen),
        .blk_mode (now_mode),
        .avail    (avail_now),
        .kind     (kind)
    );

    assign q_flush = (fifo_wr && !c_q.busy && kind == DK_FLAG) ||
                     (c_q.busy && cmd_done);

    cmdq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_wr),
        .flush (q_flush),
        .wdata (reg_wdata),
        .words (words),
        .cnt   (q_cnt)
    );

    cmdq_fields u_fld (
        .hdr_lo (words[0][23:0]),
        .pw1    (words[1]),
        .pw2    (words[2]),
        .pw3    (words[3]),
        .len    (cmd_len),
        .src    (cmd_src),
        .dst    (cmd_dst),
        .ivaddr (cmd_ivaddr)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        if (c_q.busy && (cmd_done || cmd_err)) begin
            c_d.busy = 1'b0;
        end
        if (fifo_wr && !c_q.busy) begin
            case (kind)
                DK_SEND: begin
                    c_d.valid = 1'b1;
                    c_d.busy  = 1'b1;
                end
                DK_FLAG: begin
                    if (now_raise) begin
                        c_d.ist[IST_FLAG] = 1'b1;
                    end
                    c_d.finfo = now_info;
                end
                DK_UNKNOWN: c_d.ist[IST_BADCMD] = 1'b1;
                default: ;
            endcase
        end
        if (reg_wr && reg_addr == A_IST) begin
            c_d.ist = c_q.ist & ~reg_wdata;
        end
        if (reg_wr && reg_addr == A_IEN) begin
            c_d.ien = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_STATUS: reg_rdata = STATUS_INIT;
            A_IST:    reg_rdata = c_q.ist;
            A_IEN:    reg_rdata = c_q.ien;
            A_WMARK:  reg_rdata = '0;
            A_QSTAT:  reg_rdata = QSTAT_INIT;
            A_FINFO:  reg_rdata = {24'd0, c_q.finfo};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq       = |(c_q.ist & c_q.ien);
    assign cmd_valid = c_q.valid;
    assign cmd_hdr   = words[0];
    assign cmd_op    = words[0][31:28];

    for (genvar k = 0; k < DEPTH - 1; k++) begin : g_pay
        assign cmd_payload[k*32 +: 32] = words[k+1];
    end

    // R11: the dispatch strobe lasts one cycle
    a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R11: a done response leaves the queue empty
    a_r11_done_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.busy && cmd_done) |=> (q_cnt == '0));

    // R12: while waiting, the dispatched header holds and nothing new is sent
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.busy && !cmd_done && !cmd_err) |=> (!cmd_valid && $stable(cmd_hdr)));

    // R2: an unknown opcode raises the invalid-command bit
    a_r2_badcmd: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !c_q.busy && kind == DK_UNKNOWN) |=> c_q.ist[IST_BADCMD]);

    // R6: written ones are cleared from interrupt status
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_IST) |=> ((c_q.ist & $past(reg_wdata)) == '0));
endmodule

// File: tb/sim_cmdq_seq.sv
`timescale 1ns/1ps
module sim_cmdq_seq;
    localparam int DEPTH = 9;
    localparam int AW    = 12;
    localparam int PW    = (DEPTH - 1) * 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic            cmd_done = 1'b0;
    logic            cmd_err = 1'b0;
    logic [31:0]     reg_rdata;
    logic            irq;
    logic            cmd_valid;
    logic [3:0]      cmd_op;
    logic [31:0]     cmd_hdr;
    logic [PW-1:0]   cmd_payload;
    logic [23:0]     cmd_len;
    logic [47:0]     cmd_src;
    logic [47:0]     cmd_dst;
    logic [39:0]     cmd_ivaddr;

    always #2.5 clk = ~clk;

    cmdq_seq #(.DEPTH(DEPTH), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_hdr(cmd_hdr),
        .cmd_payload(cmd_payload), .cmd_len(cmd_len), .cmd_src(cmd_src),
        .cmd_dst(cmd_dst), .cmd_ivaddr(cmd_ivaddr),
        .cmd_done(cmd_done), .cmd_err(cmd_err)
    );

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int cyc = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] mq[$];
    bit          m_busy, m_valid, was_busy, do_flush;
    logic [31:0] m_ist, m_ien;
    logic [7:0]  m_flag;
    int          n_req;

    // words needed; 0 = flag, -1 = rejected, -2 = unknown opcode
    function automatic int words_needed(input logic [31:0] h);
        case (h[31:28])
            4'h1: begin
                if (h[17:16] > 2'd1) return -1;
                if (h[26:24] != 3'd0) return 1;
                case (h[23:22])
                    2'd0: return 5;
                    2'd1: return 7;
                    2'd2: return 9;
                    default: return -1;
                endcase
            end
            4'h2: return 5;
            4'h5: return 4;
            4'h6: return 2;
            4'h8: return 0;
            default: return -2;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_busy = 0; m_valid = 0; m_ist = 0; m_ien = 0; m_flag = 0;
        end else begin
            was_busy = m_busy;
            do_flush = 0;
            m_valid  = 0;
            if (was_busy && (cmd_done || cmd_err)) begin
                m_busy = 0;
                if (cmd_done) do_flush = 1;
            end
            if (reg_wr) begin
                if (reg_addr == 12'h200) begin
                    if (mq.size() < DEPTH) mq.push_back(reg_wdata);
                    if (!was_busy) begin
                        n_req = words_needed(mq[0]);
                        if (n_req == -2) m_ist[2] = 1'b1;
                        else if (n_req == 0) begin
                            if (mq[0][27]) m_ist[5] = 1'b1;
                            m_flag = mq[0][7:0];
                            do_flush = 1;
                        end else if (n_req > 0 && mq.size() >= n_req) begin
                            m_valid = 1; m_busy = 1;
                        end
                    end
                end else if (reg_addr == 12'h018) m_ist = m_ist & ~reg_wdata;
                else if (reg_addr == 12'h01C) m_ien = reg_wdata;
            end
            if (do_flush) mq.delete();
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(irq == (|(m_ist & m_ien)), "R6 irq vs model", 64'(irq), 64'(|(m_ist & m_ien)));
            chk(cmd_valid == m_valid, "R11 strobe vs model", 64'(cmd_valid), 64'(m_valid));
            if (cmd_valid) pulses++;
            if (m_valid) begin
                chk(cmd_hdr == mq[0], "R2 header", 64'(cmd_hdr), 64'(mq[0]));
                chk(cmd_op == mq[0][31:28], "R2 opcode", 64'(cmd_op), 64'(mq[0][31:28]));
                for (int k = 1; k < mq.size(); k++)
                    chk(cmd_payload[(k-1)*32 +: 32] == mq[k], "R3 payload word",
                        64'(cmd_payload[(k-1)*32 +: 32]), 64'(mq[k]));
                if (mq[0][31:28] == 4'h5) begin
                    chk(cmd_len == mq[0][23:0], "R8 length", 64'(cmd_len), 64'(mq[0][23:0]));
                    chk(cmd_src == {mq[1][31:16], mq[2]}, "R8 source", 64'(cmd_src), 64'({mq[1][31:16], mq[2]}));
                    chk(cmd_dst == {mq[1][15:0], mq[3]}, "R8 destination", 64'(cmd_dst), 64'({mq[1][15:0], mq[3]}));
                end
                if (mq[0][31:28] == 4'h6)
                    chk(cmd_ivaddr == {mq[0][7:0], mq[1]}, "R9 iv address", 64'(cmd_ivaddr), 64'({mq[0][7:0], mq[1]}));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
            finish_up();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic reply(input bit ok);
        @(negedge clk);
        cmd_done = ok; cmd_err = !ok;
        @(negedge clk);
        cmd_done = 1'b0; cmd_err = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset values and queue port read
        rd(12'h00C, 32'h3F80, "R7 status reset");
        rd(12'h024, 32'h2, "R7 queue status reset");
        rd(12'h020, 32'h0, "R7 watermark reset");
        rd(12'h018, 32'h0, "R7 irq status reset");
        rd(12'h01C, 32'h0, "R7 irq enable reset");
        rd(12'h030, 32'h0, "R7 flag info reset");
        rd(12'h200, 32'h0, "R7 queue port reads zero");
        chk(irq == 1'b0, "R6 irq low after reset", 64'(irq), 0);

        wr(12'h01C, 32'h24);
        rd(12'h01C, 32'h24, "R6 irq enable written");

        // R5: flag with interrupt request
        wr(12'h200, 32'h8800_00A5);
        chk(irq == 1'b1, "R5 flag raises irq", 64'(irq), 1);
        rd(12'h030, 32'hA5, "R5 flag info");
        rd(12'h018, 32'h20, "R5 flag status bit");
        wr(12'h018, 32'h20);
        chk(irq == 1'b0, "R6 w1c drops irq", 64'(irq), 0);
        rd(12'h018, 32'h0, "R6 status cleared");

        // R5: flag without interrupt request
        wr(12'h200, 32'h8000_003C);
        rd(12'h030, 32'h3C, "R5 flag info quiet");
        chk(irq == 1'b0, "R5 no irq without bit 27", 64'(irq), 0);

        // R3/R4: IV load needs four payload words
        wr(12'h200, 32'h2000_0000);
        for (int k = 1; k <= 3; k++) wr(12'h200, 32'hA000_0000 + k);
        settle();
        chk(pulses == 0, "R4 incomplete IV kept, no dispatch", 64'(pulses), 0);
        wr(12'h200, 32'hA000_0004);
        settle();
        chk(pulses == 1, "R3 IV dispatched on fifth word", 64'(pulses), 1);
        reply(1'b1);
        wr(12'h200, 32'h8000_0055);
        rd(12'h030, 32'h55, "R11 done emptied queue, next flag decoded");

        // R8/R11: data command, error then retry
        wr(12'h200, 32'h5000_1234);
        wr(12'h200, 32'hAAAA_BBBB);
        wr(12'h200, 32'h1122_3344);
        wr(12'h200, 32'h5566_7788);
        settle();
        chk(pulses == 2, "R3 data dispatched", 64'(pulses), 2);
        chk(cmd_src == 48'hAAAA_1122_3344, "R8 source", 64'(cmd_src), 64'h0000_AAAA_1122_3344);
        chk(cmd_dst == 48'hBBBB_5566_7788, "R8 destination", 64'(cmd_dst), 64'h0000_BBBB_5566_7788);
        chk(cmd_len == 24'h001234, "R8 length", 64'(cmd_len), 64'h1234);
        reply(1'b0);
        wr(12'h200, 32'h0);
        settle();
        chk(pulses == 3, "R11 retry after error", 64'(pulses), 3);
        chk(cmd_src == 48'hAAAA_1122_3344, "R11 queue kept after error", 64'(cmd_src), 64'h0000_AAAA_1122_3344);
        reply(1'b1);

        // R9/R12: IV store, flag written while waiting is not decoded
        wr(12'h200, 32'h6000_00C7);
        wr(12'h200, 32'hDEAD_BEEF);
        settle();
        chk(pulses == 4, "R3 IV store dispatched", 64'(pulses), 4);
        chk(cmd_ivaddr == 40'hC7_DEAD_BEEF, "R9 iv address", 64'(cmd_ivaddr), 64'hC7_DEAD_BEEF);
        wr(12'h200, 32'h8800_0011);
        settle();
        chk(irq == 1'b0, "R12 flag while busy raises nothing", 64'(irq), 0);
        rd(12'h030, 32'h55, "R12 flag info untouched while busy");
        reply(1'b1);
        rd(12'h030, 32'h55, "R12 queued flag dropped by done");

        // R3: key variants
        wr(12'h200, 32'h1100_0000);
        settle();
        chk(pulses == 5, "R3 builtin key needs no payload", 64'(pulses), 5);
        reply(1'b1);
        wr(12'h200, 32'h1000_0000);
        for (int k = 1; k <= 3; k++) wr(12'h200, 32'hB000_0000 + k);
        settle();
        chk(pulses == 5, "R3 short key still waiting", 64'(pulses), 5);
        wr(12'h200, 32'hB000_0004);
        settle();
        chk(pulses == 6, "R3 short key dispatched", 64'(pulses), 6);
        reply(1'b1);

        // R1: widest key fills queue; dropped write during retry
        wr(12'h200, 32'h1080_0000);
        for (int k = 1; k <= 7; k++) wr(12'h200, 32'h100 + k);
        settle();
        chk(pulses == 6, "R3 long key waits for eighth word", 64'(pulses), 6);
        wr(12'h200, 32'h108);
        settle();
        chk(pulses == 7, "R3 long key dispatched", 64'(pulses), 7);
        reply(1'b0);
        wr(12'h200, 32'hFFFF_FFFF);
        settle();
        chk(pulses == 8, "R1 full queue redispatched", 64'(pulses), 8);
        chk(cmd_payload[(DEPTH-2)*32 +: 32] == 32'h108, "R1 dropped write left last word",
            64'(cmd_payload[(DEPTH-2)*32 +: 32]), 64'h108);
        reply(1'b1);

        // R3: rejected key mode
        wr(12'h200, 32'h1002_0000);
        settle();
        chk(pulses == 8, "R3 bad mode not dispatched", 64'(pulses), 8);
        rd(12'h018, 32'h0, "R3 reject sets no status bit");
        do_reset();

        // R2: unknown opcode
        wr(12'h01C, 32'h4);
        wr(12'h200, 32'h3000_0000);
        chk(irq == 1'b1, "R2 unknown opcode irq", 64'(irq), 1);
        rd(12'h018, 32'h4, "R2 invalid command bit");
        wr(12'h018, 32'h4);
        chk(irq == 1'b0, "R6 clear invalid bit", 64'(irq), 0);

        // R10: unmapped and read-only offsets
        wr(12'h040, 32'hFFFF_FFFF);
        rd(12'h040, 32'h0, "R10 unmapped read zero");
        rd(12'h01C, 32'h4, "R10 enable unchanged");
        chk(irq == 1'b0, "R10 irq unchanged low", 64'(irq), 0);
        wr(12'h200, 32'h0);
        chk(irq == 1'b1, "R2 unknown head rechecked on write", 64'(irq), 1);
        wr(12'h044, 32'hFFFF_FFFF);
        chk(irq == 1'b1, "R10 irq unchanged high", 64'(irq), 1);
        wr(12'h00C, 32'h0);
        rd(12'h00C, 32'h3F80, "R10 status write ignored");
        wr(12'h020, 32'h7);
        rd(12'h020, 32'h0, "R10 watermark write ignored");

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule